// File: doc/BRIEF.md
# Overlapping Windowed Register File

This block is a register file for a processor whose procedure calls switch register sets instead of saving registers to memory. The physical storage forms a ring of windows. Each window presents three areas of eight registers (incoming parameters, locals and outgoing temporaries), and a separate group of eight global registers is visible from every window. The outgoing area of one window is the same storage as the incoming area of the next, so a caller writes arguments into its temporaries and the callee reads them as parameters without any copy.

A call strobe moves the current window pointer one step forward around the ring, and a return strobe moves it one step back. A saved window pointer marks the oldest window still held in the file. A call that would overwrite storage still in use raises an overflow trap. The block then spills the oldest window to an external memory, one word per acknowledge, and completes the call. A return into a window that was spilled raises an underflow trap and fills that window from memory before the return completes. Reads and writes use window-relative register numbers through two read ports and one write port.

Top module: `win_regfile`

## Requirements
- R1: After reset the current and saved window pointers are 0, both trap outputs and the memory request are low, and every register reads as 0.
- R2: Register number bits [4:3] select the area: 0 selects a global, 1 a parameter, 2 a local and 3 a temporary, with bits [2:0] as the offset. A global holds the same value whatever the current window.
- R3: A call strobe with no trap advances the current window pointer by one and a return strobe moves it back by one, both wrapping modulo the window count. The pointer changes on the clock edge that samples the strobe. When call and return are both high in the same cycle, nothing changes.
- R4: A value written to temporary k in window w reads back as parameter k in window w+1, and a parameter written in window w+1 reads back as temporary k in window w after the return.
- R5: Locals are private to their window: window w+1 does not see the locals of window w, and those locals keep their values across a call and the matching return.
- R6: A call made when the current pointer plus two equals the saved pointer (modulo the window count) raises the overflow trap instead of moving. The block then requests sixteen words for the window named by the saved pointer, with word index 0 to 7 carrying its locals 0 to 7 and index 8 to 15 its parameters 0 to 7 on the write-data output. One word advances per acknowledge. After the sixteenth acknowledge both pointers advance by one and the trap drops.
- R7: A return made when the current pointer equals the saved pointer raises the underflow trap. The block then requests sixteen words for the window one below the current pointer, with the same index-to-register layout as R6, and loads each word from the read-data input at its acknowledge. After the sixteenth acknowledge both pointers move back by one and the trap drops.
- R8: While either trap is active, call and return strobes and writes from the write port have no effect.
- R9: When a read port addresses the same physical register that the write port writes in the same cycle, that read port returns the value being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| callReq | input | 1 | Call strobe |
| retReq | input | 1 | Return strobe |
| rdAddrA | input | 5 | Window-relative register number, read port A |
| rdDataA | output | 32 | Read data, port A |
| rdAddrB | input | 5 | Window-relative register number, read port B |
| rdDataB | output | 32 | Read data, port B |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Window-relative register number, write port |
| wrData | input | 32 | Write data |
| curWin | output | 3 | Current window pointer |
| savedWin | output | 3 | Saved window pointer (oldest resident window) |
| ovfTrap | output | 1 | High while a spill is in progress |
| unfTrap | output | 1 | High while a fill is in progress |
| memReq | output | 1 | Transfer word request |
| memWin | output | 3 | Window being spilled or filled |
| memIdx | output | 4 | Word index within the window transfer |
| memWdata | output | 32 | Spill data for the current word |
| memAck | input | 1 | Memory accepts or supplies the current word |
| memRdata | input | 32 | Fill data for the current word |

## Verification
Two things can happen in one cycle: a write and a read of the same physical register, and a call strobe or port write arriving while a spill is running. The first is provoked by driving both read addresses and the write address to one register with the write enabled. The read data is sampled before the edge and must already show the new value. The second is provoked by raising the call strobe and writing a global in the middle of a spill. It is judged by the pointers after the spill, which must move by exactly one step, and by the global, which must still read 0.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

  // Area selected by the two upper bits of a window-relative register number.
  typedef enum logic [1:0] {
    AREA_GLOB  = 2'd0,
    AREA_PARAM = 2'd1,
    AREA_LOCAL = 2'd2,
    AREA_TEMP  = 2'd3
  } areaSel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2
  } ctlState_e;

  // Strobes handed from control to datapath each cycle.
  typedef struct packed {
    logic fillWrite;    // store fill word at the transfer register
    logic userWriteOk;  // write port may update storage
  } ctlStrobe_t;

endpackage

// File: rtl/wrf_ctrl.sv
module wrf_ctrl
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int AREA = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       callReq,
  input  logic                       retReq,
  input  logic                       memAck,
  output logic [$clog2(NWIN)-1:0]    cwp,
  output logic [$clog2(NWIN)-1:0]    swp,
  output logic [$clog2(NWIN)-1:0]    xferWin,
  output logic [$clog2(AREA)+1:0]    xferReg,
  output logic [$clog2(AREA):0]      xferIdx,
  output ctlStrobe_t                 strobes,
  output logic                       ovfTrap,
  output logic                       unfTrap,
  output logic                       memReq
);

  localparam int WW = $clog2(NWIN);
  localparam int AW = $clog2(AREA);
  localparam int XW = AW + 1;

  ctlState_e state;
  logic [XW-1:0] idx;
  logic callGo, retGo, ovfHit, unfHit, lastWord;

  assign callGo   = (state == ST_IDLE) && callReq && !retReq;
  assign retGo    = (state == ST_IDLE) && retReq && !callReq;
  assign ovfHit   = (cwp + WW'(2)) == swp;
  assign unfHit   = (cwp == swp);
  assign lastWord = (idx == {XW{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cwp   <= '0;
      swp   <= '0;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (callGo) begin
            if (ovfHit) begin
              state <= ST_SPILL;
              idx   <= '0;
            end else begin
              cwp <= cwp + WW'(1);
            end
          end else if (retGo) begin
            if (unfHit) begin
              state <= ST_FILL;
              idx   <= '0;
            end else begin
              cwp <= cwp - WW'(1);
            end
          end
        end
        ST_SPILL, ST_FILL: begin
          if (memAck) begin
            idx <= idx + XW'(1);
            if (lastWord) begin
              state <= ST_IDLE;
              if (state == ST_SPILL) begin
                swp <= swp + WW'(1);
                cwp <= cwp + WW'(1);
              end else begin
                swp <= swp - WW'(1);
                cwp <= cwp - WW'(1);
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Spill takes the oldest resident window; fill restores the one below cwp.
  assign xferWin = (state == ST_FILL) ? (cwp - WW'(1)) : swp;
  assign xferReg = {(idx[AW] ? AREA_PARAM : AREA_LOCAL), idx[AW-1:0]};
  assign xferIdx = idx;

  assign strobes.fillWrite   = (state == ST_FILL) && memAck;
  assign strobes.userWriteOk = (state == ST_IDLE);

  assign ovfTrap = (state == ST_SPILL);
  assign unfTrap = (state == ST_FILL);
  assign memReq  = (state != ST_IDLE);

  assert_call_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    (callGo && !ovfHit) |=> (cwp == $past(cwp) + WW'(1)));

  assert_return_back_R3: assert property (@(posedge clk) disable iff (!rstN)
    (retGo && !unfHit) |=> (cwp == $past(cwp) - WW'(1)));

  assert_no_move_both_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && callReq && retReq) |=> $stable(cwp) && !memReq);

  assert_overflow_trap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (callGo && ovfHit) |=> (ovfTrap && $stable(cwp) && (xferIdx == '0)));

  assert_underflow_trap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (retGo && unfHit) |=> (unfTrap && $stable(cwp) && (xferIdx == '0)));

  assert_spill_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ovfTrap && memAck && lastWord) |=>
      (!ovfTrap && (swp == $past(swp) + WW'(1)) && (cwp == $past(cwp) + WW'(1))));

  assert_fill_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    (unfTrap && memAck && lastWord) |=>
      (!unfTrap && (swp == $past(swp) - WW'(1)) && (cwp == $past(cwp) - WW'(1))));

  assert_trap_freeze_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !(memAck && lastWord)) |=> ($stable(cwp) && $stable(swp)));

  assert_one_trap_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ovfTrap, unfTrap}));

endmodule

// File: rtl/wrf_datapath.sv
module wrf_datapath
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int AREA = 8,
  parameter int DW   = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [$clog2(NWIN)-1:0]  cwp,
  input  ctlStrobe_t               strobes,
  input  logic                     wrEn,
  input  logic [$clog2(AREA)+1:0]  wrAddr,
  input  logic [DW-1:0]            wrData,
  input  logic [$clog2(AREA)+1:0]  rdAddrA,
  input  logic [$clog2(AREA)+1:0]  rdAddrB,
  output logic [DW-1:0]            rdDataA,
  output logic [DW-1:0]            rdDataB,
  input  logic [$clog2(NWIN)-1:0]  xferWin,
  input  logic [$clog2(AREA)+1:0]  xferReg,
  output logic [DW-1:0]            spillData,
  input  logic [DW-1:0]            fillData
);

  localparam int WW    = $clog2(NWIN);
  localparam int AW    = $clog2(AREA);
  localparam int RW    = AW + 2;
  localparam int NPHYS = AREA + NWIN * 2 * AREA;
  localparam int PW    = $clog2(NPHYS);

  // Globals first, then per window a local block followed by an outgoing block.
  // Parameters of window w are the outgoing block of window w-1.
  function automatic logic [PW-1:0] mapReg(input logic [WW-1:0] w,
                                           input logic [RW-1:0] r);
    areaSel_e        a;
    logic [WW-1:0]   blk;
    logic [PW-1:0]   base;
    logic [PW-1:0]   off;
    a    = areaSel_e'(r[RW-1:AW]);
    off  = PW'(r[AW-1:0]);
    blk  = (a == AREA_PARAM) ? (w - WW'(1)) : w;
    base = PW'(AREA) + (PW'(blk) << (AW + 1));
    case (a)
      AREA_GLOB:  return off;
      AREA_LOCAL: return base + off;
      default:    return base + PW'(AREA) + off;
    endcase
  endfunction

  logic [DW-1:0] rf [NPHYS];
  logic [PW-1:0] physW, physA, physB, physX;
  logic          userWr;

  assign physW  = mapReg(cwp, wrAddr);
  assign physA  = mapReg(cwp, rdAddrA);
  assign physB  = mapReg(cwp, rdAddrB);
  assign physX  = mapReg(xferWin, xferReg);
  assign userWr = wrEn && strobes.userWriteOk;

  assign rdDataA   = (userWr && (physW == physA)) ? wrData : rf[physA];
  assign rdDataB   = (userWr && (physW == physB)) ? wrData : rf[physB];
  assign spillData = rf[physX];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NPHYS; i++) rf[i] <= '0;
    end else if (strobes.fillWrite) begin
      rf[physX] <= fillData;
    end else if (userWr) begin
      rf[physW] <= wrData;
    end
  end

  assert_fill_lands_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fillWrite |=> (rf[$past(physX)] == $past(fillData)));

  assert_write_blocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !strobes.userWriteOk && !strobes.fillWrite) |=>
      (rf[$past(physW)] == $past(rf[physW])));

  assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rstN)
    (userWr && !strobes.fillWrite) |=> (rf[$past(physW)] == $past(wrData)));

endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int AREA = 8,
  parameter int DW   = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     callReq,
  input  logic                     retReq,
  input  logic [$clog2(AREA)+1:0]  rdAddrA,
  output logic [DW-1:0]            rdDataA,
  input  logic [$clog2(AREA)+1:0]  rdAddrB,
  output logic [DW-1:0]            rdDataB,
  input  logic                     wrEn,
  input  logic [$clog2(AREA)+1:0]  wrAddr,
  input  logic [DW-1:0]            wrData,
  output logic [$clog2(NWIN)-1:0]  curWin,
  output logic [$clog2(NWIN)-1:0]  savedWin,
  output logic                     ovfTrap,
  output logic                     unfTrap,
  output logic                     memReq,
  output logic [$clog2(NWIN)-1:0]  memWin,
  output logic [$clog2(AREA):0]    memIdx,
  output logic [DW-1:0]            memWdata,
  input  logic                     memAck,
  input  logic [DW-1:0]            memRdata
);

  localparam int WW = $clog2(NWIN);
  localparam int RW = $clog2(AREA) + 2;

  if (((NWIN & (NWIN - 1)) != 0) || (NWIN < 4) || ((AREA & (AREA - 1)) != 0) || (AREA < 2)) begin : gBadCfg
    $error("win_regfile: NWIN must be a power of two >= 4 and AREA a power of two >= 2");
  end

  ctlStrobe_t    strobes;
  logic [WW-1:0] cwp, swp, xferWin;
  logic [RW-1:0] xferReg;

  wrf_ctrl #(.NWIN(NWIN), .AREA(AREA)) uCtrl (
    .clk(clk), .rstN(rstN), .callReq(callReq), .retReq(retReq), .memAck(memAck),
    .cwp(cwp), .swp(swp), .xferWin(xferWin), .xferReg(xferReg), .xferIdx(memIdx),
    .strobes(strobes), .ovfTrap(ovfTrap), .unfTrap(unfTrap), .memReq(memReq)
  );

  wrf_datapath #(.NWIN(NWIN), .AREA(AREA), .DW(DW)) uData (
    .clk(clk), .rstN(rstN), .cwp(cwp), .strobes(strobes),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .xferWin(xferWin), .xferReg(xferReg), .spillData(memWdata), .fillData(memRdata)
  );

  assign curWin   = cwp;
  assign savedWin = swp;
  assign memWin   = xferWin;

endmodule

// File: tb/win_regfile_test.sv
`timescale 1ns/1ps
module win_regfile_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        callReq = 1'b0, retReq = 1'b0;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0;
  logic        wrEn = 1'b0;
  logic [2:0]  curWin, savedWin, memWin;
  logic        ovfTrap, unfTrap, memReq, memAck = 1'b0;
  logic [3:0]  memIdx;
  logic [31:0] memWdata, memRdata = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  win_regfile uut (
    .clk(clk), .rstN(rstN), .callReq(callReq), .retReq(retReq),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .curWin(curWin), .savedWin(savedWin), .ovfTrap(ovfTrap), .unfTrap(unfTrap),
    .memReq(memReq), .memWin(memWin), .memIdx(memIdx), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  // op: 0 write, 1 read check on both ports, 2 call, 3 return; win = expected cwp after
  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  rg;
    logic [31:0] val;
    logic [2:0]  win;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 5'd1,  32'h0000_1111, 3'd0},  // global 1
    '{2'd0, 5'd16, 32'h0000_00A0, 3'd0},  // local 0 of window 0
    '{2'd0, 5'd26, 32'h0000_00B2, 3'd0},  // temp 2 of window 0
    '{2'd2, 5'd0,  32'h0,         3'd1},  // call (R3)
    '{2'd1, 5'd10, 32'h0000_00B2, 3'd1},  // R4: temp 2 -> param 2
    '{2'd1, 5'd16, 32'h0,         3'd1},  // R5: locals private
    '{2'd1, 5'd1,  32'h0000_1111, 3'd1},  // R2: global shared
    '{2'd0, 5'd11, 32'h0000_00C3, 3'd1},  // param 3 of window 1
    '{2'd0, 5'd16, 32'h0000_00A1, 3'd1},  // local 0 of window 1
    '{2'd3, 5'd0,  32'h0,         3'd0},  // return (R3)
    '{2'd1, 5'd27, 32'h0000_00C3, 3'd0},  // R4: param 3 -> temp 3
    '{2'd1, 5'd16, 32'h0000_00A0, 3'd0},  // R5: local kept
    '{2'd1, 5'd1,  32'h0000_1111, 3'd0}   // R2
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doCall();
    @(negedge clk) callReq = 1'b1;
    @(negedge clk) callReq = 1'b0;
  endtask

  task automatic doRet();
    @(negedge clk) retReq = 1'b1;
    @(negedge clk) retReq = 1'b0;
  endtask

  task automatic doWrite(input logic [4:0] rg, input logic [31:0] v);
    @(negedge clk) begin wrEn = 1'b1; wrAddr = rg; wrData = v; end
    @(negedge clk) wrEn = 1'b0;
  endtask

  task automatic readChk(input logic [4:0] rg, input logic [31:0] exp, input string tag);
    rdAddrA = rg; rdAddrB = rg;
    #1;
    chk(rdDataA == exp, {tag, " port A"}, rdDataA, exp);
    chk(rdDataB == exp, {tag, " port B"}, rdDataB, exp);
  endtask

  // Services a 16-word transfer; called at the negedge where the trap is visible.
  task automatic xferSvc(input logic [2:0] expWin, input bit isFill, input bit chkData,
                         input logic [31:0] base, input bit inject, input string tag);
    for (int i = 0; i < 16; i++) begin
      chk(memReq == 1'b1, {tag, " memReq"}, 32'(memReq), 32'd1);
      chk((isFill ? unfTrap : ovfTrap) == 1'b1, {tag, " trap level"}, 32'(isFill ? unfTrap : ovfTrap), 32'd1);
      chk(memWin == expWin, {tag, " memWin"}, 32'(memWin), 32'(expWin));
      chk(memIdx == 4'(i), {tag, " memIdx"}, 32'(memIdx), 32'(i));
      if (!isFill && chkData)
        chk(memWdata == base + 32'(i), {tag, " spill word"}, memWdata, base + 32'(i));
      memRdata = base + 32'(i);
      memAck = 1'b1;
      if (inject && i == 3) begin  // R8: strobe and write during trap
        callReq = 1'b1; wrEn = 1'b1; wrAddr = 5'd5; wrData = 32'hDEAD_BEEF;
      end
      @(negedge clk);
      memAck = 1'b0; callReq = 1'b0; wrEn = 1'b0;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(curWin == 3'd0, "R1 curWin", 32'(curWin), 32'd0);
    chk(savedWin == 3'd0, "R1 savedWin", 32'(savedWin), 32'd0);
    chk({ovfTrap, unfTrap, memReq} == 3'b000, "R1 traps", 32'({ovfTrap, unfTrap, memReq}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    readChk(5'd16, 32'd0, "R1 local reset");
    readChk(5'd3, 32'd0, "R1 global reset");

    // Vector table: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      case (VECS[v].op)
        2'd0: doWrite(VECS[v].rg, VECS[v].val);
        2'd1: readChk(VECS[v].rg, VECS[v].val, $sformatf("R2 R4 R5 vector %0d", v));
        2'd2: doCall();
        default: doRet();
      endcase
      chk(curWin == VECS[v].win, $sformatf("R3 vector %0d window", v), 32'(curWin), 32'(VECS[v].win));
    end

    // R9 read during write, both ports, sampled before the edge
    @(negedge clk) begin wrEn = 1'b1; wrAddr = 5'd20; wrData = 32'h5A5A_0001; end
    readChk(5'd20, 32'h5A5A_0001, "R9 bypass");
    @(negedge clk) wrEn = 1'b0;
    readChk(5'd20, 32'h5A5A_0001, "R9 stored");

    // R3 call and return together
    @(negedge clk) begin callReq = 1'b1; retReq = 1'b1; end
    @(negedge clk) begin callReq = 1'b0; retReq = 1'b0; end
    chk(curWin == 3'd0, "R3 call+return no move", 32'(curWin), 32'd0);
    chk(memReq == 1'b0, "R3 call+return no trap", 32'(memReq), 32'd0);

    // Markers in window 0: locals 0x100+k, params 0x108+k
    for (int k = 0; k < 8; k++) begin
      doWrite(5'(16 + k), 32'h100 + 32'(k));
      doWrite(5'(8 + k), 32'h108 + 32'(k));
    end

    // Six calls fit without a trap
    for (int c = 1; c <= 6; c++) begin
      doCall();
      chk(curWin == 3'(c), "R3 call advance", 32'(curWin), 32'(c));
      chk(ovfTrap == 1'b0, "R6 no early trap", 32'(ovfTrap), 32'd0);
    end
    // R6 overflow: cwp 6 + 2 == swp 0
    doCall();
    chk(curWin == 3'd6, "R6 call held", 32'(curWin), 32'd6);
    xferSvc(3'd0, 1'b0, 1'b1, 32'h100, 1'b1, "R6 spill");
    chk(ovfTrap == 1'b0, "R6 trap drops", 32'(ovfTrap), 32'd0);
    chk(curWin == 3'd7, "R6 R8 cwp after spill", 32'(curWin), 32'd7);
    chk(savedWin == 3'd1, "R6 swp after spill", 32'(savedWin), 32'd1);
    readChk(5'd5, 32'd0, "R8 write ignored");

    // Second spill; cwp wraps 7 -> 0
    doCall();
    xferSvc(3'd1, 1'b0, 1'b0, 32'h0, 1'b0, "R6 spill2");
    chk(curWin == 3'd0, "R3 wrap forward", 32'(curWin), 32'd0);
    chk(savedWin == 3'd2, "R6 swp2", 32'(savedWin), 32'd2);

    doRet();
    chk(curWin == 3'd7, "R3 wrap back", 32'(curWin), 32'd7);
    for (int c = 6; c >= 2; c--) begin
      doRet();
      chk(curWin == 3'(c), "R3 return back", 32'(curWin), 32'(c));
      chk(unfTrap == 1'b0, "R7 no early trap", 32'(unfTrap), 32'd0);
    end
    // R7 underflow: cwp == swp == 2
    doRet();
    chk(curWin == 3'd2, "R7 return held", 32'(curWin), 32'd2);
    xferSvc(3'd1, 1'b1, 1'b0, 32'h400, 1'b0, "R7 fill1");
    chk(curWin == 3'd1 && savedWin == 3'd1, "R7 pointers after fill1",
        32'({curWin, savedWin}), 32'({3'd1, 3'd1}));
    doRet();
    xferSvc(3'd0, 1'b1, 1'b0, 32'h300, 1'b0, "R7 fill0");
    chk(unfTrap == 1'b0, "R7 trap drops", 32'(unfTrap), 32'd0);
    chk(curWin == 3'd0 && savedWin == 3'd0, "R7 pointers after fill0",
        32'({curWin, savedWin}), 32'd0);
    readChk(5'd16, 32'h300, "R7 fill local 0");
    readChk(5'd23, 32'h307, "R7 fill local 7");
    readChk(5'd8,  32'h308, "R7 fill param 0");
    readChk(5'd15, 32'h30F, "R7 fill param 7");
    readChk(5'd1,  32'h1111, "R2 global after traps");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule